// File: doc/BRIEF.md
# Narrow Multiplexed Peripheral Bus Controller

This block is the slave end of a 32-bit APB-style register port. It turns each register access into a sequence of byte-wide cycles on an 8-bit bus that carries both address and data, the kind of bus that slow flash or glue-logic devices use. A 25-bit address goes out in four phases. The fourth phase carries only the top address bit. After the address, the block runs one of two loops.

On a write, each byte of the 32-bit word is driven in turn, least-significant byte first. Each byte passes through a programmable setup, strobe and hold window. On a read, the block enables the device's output driver and runs a setup and strobe window for each byte. It samples the bus and packs the four bytes into the read word. Once the read is done, it acknowledges the transfer.

Every access ends with one acknowledge cycle and one bus-release cycle before the bus can be driven again. Each state has a fixed 4-bit code. Entering a state raises a one-cycle pulse on the event bit with that code, so a performance counter can count state entries.

Top module: `mux8_bus_ctrl`

## Requirements
- R1: While reset is held and in the idle state (code 0x0) after it, the bus is released: chip select high, both strobes high, address latch low, data driver off, driven byte zero, ready low.
- R2: An access starts from idle when psel is high with penable low. The four address phases then drive, in order, paddr[7:0] (code 0x3), paddr[15:8] (code 0x2), paddr[23:16] (code 0x6), and {7'b0, paddr[24]} (code 0x7). The address latch is high and the data driver is on in these phases.
- R3: A write (pwrite high at the start) presents the four bytes of pwdata, least-significant first. Each byte is driven through the unpack (0x5), setup (0x4), strobe (0xC) and hold (0xE) states. The write strobe is low only in the strobe state.
- R4: The setup, strobe and hold states last N+1 cycles each. N is the 4-bit value on cfg_setup, cfg_pulse or cfg_hold when the state is entered.
- R5: A read passes through the output-enable state (0xF) after the address. The read strobe stays low from that state until the end of the final hold. The data driver stays off for the whole read.
- R6: A read repeats setup, strobe, capture (0xB) and pack (0xD) four times, then runs one hold. The bus byte is sampled at the clock edge that ends each capture state. prdata holds the bytes packed least-significant first by the acknowledge cycle.
- R7: pready is high only in the acknowledge state (0x9), for exactly one cycle per access. pslverr is always low.
- R8: The acknowledge state is followed by one bus-release state (0x8), with chip select high and the driver off, and then idle. A new access can start in that idle cycle.
- R9: evt_o bit k pulses high for one cycle in the first cycle of each entry into the state coded k. evt_o is zero while a state is held and in reset.
- R10: The data driver is never on while the read strobe is low.
- R11: Chip select is low in every state from start (0x1) through acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 25 | APB address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | Packed read data |
| pready | output | 1 | Transfer acknowledge |
| pslverr | output | 1 | Error response, tied low |
| cfg_setup | input | 4 | Setup dwell minus one |
| cfg_pulse | input | 4 | Strobe dwell minus one |
| cfg_hold | input | 4 | Hold dwell minus one |
| bus_ad_i | input | 8 | Byte from the device |
| bus_ad_o | output | 8 | Byte driven toward the device |
| bus_ad_oe | output | 1 | Driver enable for bus_ad_o |
| bus_ale | output | 1 | Address latch strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Read strobe and device output enable, active low |
| evt_o | output | 16 | State-entry event pulses, indexed by state code |

## Verification
The bench builds the block with its default parameters: a 25-bit address, a 32-bit word, an 8-bit bus and 4-bit timing fields. At these values there are four data bytes and the last address phase carries a single bit. Between accesses the bench moves the three timing inputs across 0, 1 and 15. This exercises both the one-cycle minimum dwell and the sixteen-cycle maximum in each timed state. The addresses it uses set and clear the top bit. The read words contain lanes of all ones and single set bits, and the device model drives a different byte outside the capture cycles, so a sample taken in the wrong cycle shows up in prdata.

// File: rtl/mux8_pkg.sv
package mux8_pkg;
   typedef enum logic [3:0] {
      ST_IDLE  = 4'h0,
      ST_START = 4'h1,
      ST_ADR1  = 4'h3,
      ST_ADR2  = 4'h2,
      ST_ADR3  = 4'h6,
      ST_ADR4  = 4'h7,
      ST_WDAT  = 4'h5,
      ST_SETUP = 4'h4,
      ST_PULSE = 4'hC,
      ST_HOLD  = 4'hE,
      ST_OUTEN = 4'hF,
      ST_PACK  = 4'hD,
      ST_CAPT  = 4'hB,
      ST_READY = 4'h9,
      ST_TURN  = 4'h8
   } mst_e;

   localparam int unsigned ST_W  = 4;
   localparam int unsigned EVT_W = 2 ** ST_W;
endpackage

// File: rtl/mux8_seq.sv
module mux8_seq
   import mux8_pkg::*;
#(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned NB    = 4,
   localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [CNT_W-1:0] cfg_setup,
   input  logic [CNT_W-1:0] cfg_pulse,
   input  logic [CNT_W-1:0] cfg_hold,
   output mst_e             state_o,
   output mst_e             nxt_o,
   output logic             wr_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             accept_o
);
   mst_e             state_q, nxt;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;
   logic             wr_q;
   logic             last, cnt_zero, step_byte;

   assign cnt_zero  = (cnt_q == '0);
   assign last      = (idx_q == IDX_W'(NB - 1));
   assign accept_o  = (state_q == ST_IDLE) && psel && !penable;
   assign step_byte = wr_q ? (state_q == ST_HOLD && cnt_zero) : (state_q == ST_PACK);

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept_o) nxt = ST_START;
         ST_START: nxt = ST_ADR1;
         ST_ADR1:  nxt = ST_ADR2;
         ST_ADR2:  nxt = ST_ADR3;
         ST_ADR3:  nxt = ST_ADR4;
         ST_ADR4:  nxt = wr_q ? ST_WDAT : ST_OUTEN;
         ST_WDAT:  nxt = ST_SETUP;
         ST_OUTEN: nxt = ST_SETUP;
         ST_SETUP: if (cnt_zero) nxt = ST_PULSE;
         ST_PULSE: if (cnt_zero) nxt = wr_q ? ST_HOLD : ST_CAPT;
         ST_CAPT:  nxt = ST_PACK;
         ST_PACK:  nxt = last ? ST_HOLD : ST_SETUP;
         ST_HOLD:  if (cnt_zero) nxt = (wr_q && !last) ? ST_WDAT : ST_READY;
         ST_READY: nxt = ST_TURN;
         ST_TURN:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         wr_q    <= 1'b0;
      end else begin
         state_q <= nxt;
         if (nxt != state_q) begin
            unique case (nxt)
               ST_SETUP: cnt_q <= cfg_setup;
               ST_PULSE: cnt_q <= cfg_pulse;
               ST_HOLD:  cnt_q <= cfg_hold;
               default:  cnt_q <= '0;
            endcase
         end else if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (accept_o) begin
            wr_q  <= pwrite;
            idx_q <= '0;
         end else if (step_byte) begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign state_o = state_q;
   assign nxt_o   = nxt;
   assign wr_o    = wr_q;
   assign idx_o   = idx_q;

   // R4: a timed state is held only while its counter steps down by one each cycle
   a_r4_dwell_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == $past(state_q)) &&
       (state_q == ST_SETUP || state_q == ST_PULSE || state_q == ST_HOLD))
      |-> ((cnt_q + 1'b1) == $past(cnt_q)));

   // R6: every capture is followed directly by a pack
   a_r6_capture_then_pack: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CAPT) |=> (state_q == ST_PACK));

   // R8: acknowledge is always followed by the release state
   a_r8_ready_then_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY) |=> (state_q == ST_TURN));
endmodule

// File: rtl/mux8_dp.sv
module mux8_dp
   import mux8_pkg::*;
#(
   parameter int unsigned ADDR_W = 25,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BUS_W  = 8,
   localparam int unsigned NB    = DATA_W / BUS_W,
   localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1,
   localparam int unsigned TOP_W = ADDR_W - 3 * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  mst_e              state,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BUS_W-1:0]  ad_i,
   output logic [BUS_W-1:0]  ad_o,
   output logic              ad_oe,
   output logic              ale,
   output logic              cs_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [DATA_W-1:0] rdata
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [BUS_W-1:0]  cap_q;
   logic [BUS_W-1:0]  adr4, wbyte;
   logic              in_adr, in_wr, in_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         cap_q   <= '0;
      end else begin
         if (accept) begin
            addr_q  <= paddr;
            wdata_q <= pwdata;
         end
         if (state == ST_CAPT) cap_q <= ad_i;
      end
   end

   // last address phase: full byte or zero-padded remainder
   generate
      if (TOP_W == BUS_W) begin : g_adr4_full
         assign adr4 = addr_q[ADDR_W-1 -: BUS_W];
      end else begin : g_adr4_pad
         assign adr4 = {{(BUS_W - TOP_W){1'b0}}, addr_q[ADDR_W-1:3*BUS_W]};
      end
   endgenerate

   // read lanes, one register per byte position
   generate
      for (genvar l = 0; l < NB; l++) begin : g_lane
         logic [BUS_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else if (state == ST_PACK && idx == IDX_W'(l)) lane_q <= cap_q;
         end
         assign rdata[l*BUS_W +: BUS_W] = lane_q;
      end
   endgenerate

   assign wbyte  = wdata_q[idx*BUS_W +: BUS_W];
   assign in_adr = (state == ST_ADR1) || (state == ST_ADR2) ||
                   (state == ST_ADR3) || (state == ST_ADR4);
   assign in_wr  = wr && ((state == ST_WDAT) || (state == ST_SETUP) ||
                          (state == ST_PULSE) || (state == ST_HOLD));
   assign in_rd  = !wr && ((state == ST_OUTEN) || (state == ST_SETUP) ||
                           (state == ST_PULSE) || (state == ST_CAPT) ||
                           (state == ST_PACK) || (state == ST_HOLD));

   always_comb begin
      unique case (state)
         ST_ADR1: ad_o = addr_q[BUS_W-1:0];
         ST_ADR2: ad_o = addr_q[2*BUS_W-1:BUS_W];
         ST_ADR3: ad_o = addr_q[3*BUS_W-1:2*BUS_W];
         ST_ADR4: ad_o = adr4;
         default: ad_o = in_wr ? wbyte : '0;
      endcase
   end

   assign ad_oe = in_adr || in_wr;
   assign ale   = in_adr;
   assign cs_n  = (state == ST_IDLE) || (state == ST_TURN);
   assign we_n  = !(wr && state == ST_PULSE);
   assign oe_n  = !in_rd;

   // R10: driver and device output enable are never on together
   a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> oe_n);

   // R3: the write strobe only fires while a data byte is driven, never with the latch
   a_r3_strobe_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (ad_oe && !ale && !cs_n));
endmodule

// File: rtl/mux8_evt.sv
module mux8_evt
   import mux8_pkg::*;
#(
   localparam int unsigned N = EVT_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] state,
   input  logic [ST_W-1:0] nxt,
   output logic [N-1:0]    evt
);
   logic ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= 1'b0;
      else        ent_q <= (nxt != state);
   end

   generate
      for (genvar k = 0; k < N; k++) begin : g_evt
         assign evt[k] = ent_q && (state == ST_W'(k));
      end
   endgenerate

   // R9: at most one event bit at a time
   a_r9_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt));

   // R9: an event bit never stays high two cycles in a row
   a_r9_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> (evt != $past(evt)));
endmodule

// File: rtl/mux8_bus_ctrl.sv
module mux8_bus_ctrl
   import mux8_pkg::*;
#(
   parameter int unsigned ADDR_W = 25,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CNT_W  = 4,
   localparam int unsigned NB    = DATA_W / BUS_W,
   localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_pulse,
   input  logic [CNT_W-1:0]  cfg_hold,
   input  logic [BUS_W-1:0]  bus_ad_i,
   output logic [BUS_W-1:0]  bus_ad_o,
   output logic              bus_ad_oe,
   output logic              bus_ale,
   output logic              bus_cs_n,
   output logic              bus_we_n,
   output logic              bus_oe_n,
   output logic [EVT_W-1:0]  evt_o
);
   generate
      if (DATA_W % BUS_W != 0 || NB < 2 || (NB & (NB - 1)) != 0) begin : g_bad_word
         $error("word width must be a power-of-two multiple of the bus width");
      end
      if (ADDR_W <= 3 * BUS_W || ADDR_W > 4 * BUS_W) begin : g_bad_addr
         $error("address must need exactly four bus phases");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("timing field needs at least one bit");
      end
   endgenerate

   mst_e             state, nxt;
   logic             wr, accept;
   logic [IDX_W-1:0] idx;

   mux8_seq #(.CNT_W(CNT_W), .NB(NB)) u_seq (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
      .state_o(state), .nxt_o(nxt), .wr_o(wr), .idx_o(idx), .accept_o(accept)
   );

   mux8_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .paddr(paddr), .pwdata(pwdata),
      .state(state), .wr(wr), .idx(idx), .ad_i(bus_ad_i), .ad_o(bus_ad_o),
      .ad_oe(bus_ad_oe), .ale(bus_ale), .cs_n(bus_cs_n), .we_n(bus_we_n),
      .oe_n(bus_oe_n), .rdata(prdata)
   );

   mux8_evt u_evt (
      .clk(clk), .rst_n(rst_n), .state(state), .nxt(nxt), .evt(evt_o)
   );

   assign pready  = (state == ST_READY);
   assign pslverr = 1'b0;

   // R7: the acknowledge lasts a single cycle
   a_r7_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pready |=> !pready);

   // R11: chip select is active whenever the transfer is acknowledged
   a_r11_cs_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pready |-> !bus_cs_n);
endmodule

// File: tb/mux8_bus_ctrl_bench.sv
module mux8_bus_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 20000;

   typedef struct {
      logic [3:0]  code;
      logic        first;
      logic        ad_oe;
      logic [7:0]  ad_o;
      logic        ale, cs_n, we_n, oe_n, pready;
      logic        rdchk;
      logic [31:0] rd;
      logic [7:0]  drv;
   } rec_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [24:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [3:0]  cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0;
   logic [7:0]  bus_ad_i = 8'hFF;
   logic [7:0]  bus_ad_o;
   logic        bus_ad_oe, bus_ale, bus_cs_n, bus_we_n, bus_oe_n;
   logic [15:0] evt_o;

   int   n_vec = 0, n_fail = 0, cyc = 0;
   bit   done = 1'b0;
   rec_t exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   mux8_bus_ctrl u_mux8_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
      .cfg_hold(cfg_hold), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
      .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
      .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .evt_o(evt_o)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL R8 watchdog: actual still busy at cycle %0d, expected finished", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   function automatic string tag(input logic [3:0] c);
      case (c)
         4'h0: return "R1";
         4'h1: return "R11";
         4'h3, 4'h2, 4'h6, 4'h7: return "R2";
         4'h5: return "R3";
         4'h4, 4'hC, 4'hE: return "R4";
         4'hF: return "R5";
         4'hB, 4'hD: return "R6";
         4'h9: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic rec_t idle_rec();
      rec_t r;
      r.code = 4'h0; r.first = 1'b0; r.ad_oe = 1'b0; r.ad_o = '0; r.ale = 1'b0;
      r.cs_n = 1'b1; r.we_n = 1'b1; r.oe_n = 1'b1; r.pready = 1'b0;
      r.rdchk = 1'b0; r.rd = '0; r.drv = 8'hFF;
      return r;
   endfunction

   task automatic push(input logic [3:0] c, input int n, input logic oe,
                       input logic [7:0] d, input logic al, input logic cs,
                       input logic we, input logic re, input logic rdy,
                       input logic [7:0] drv);
      for (int i = 0; i < n; i++) begin
         rec_t r;
         r = idle_rec();
         r.code = c; r.first = (i == 0); r.ad_oe = oe; r.ad_o = d; r.ale = al;
         r.cs_n = cs; r.we_n = we; r.oe_n = re; r.pready = rdy; r.drv = drv;
         exp_q.push_back(r);
      end
   endtask

   // expected bus trace of one access, from the requirements
   task automatic plan(input bit wr, input logic [24:0] a, input logic [31:0] wd,
                       input logic [31:0] rd, input int s, input int p, input int h);
      rec_t r;
      push(4'h1, 1, 0, 8'h00, 0, 0, 1, 1, 0, 8'hFF);
      push(4'h3, 1, 1, a[7:0],   1, 0, 1, 1, 0, 8'hFF);
      push(4'h2, 1, 1, a[15:8],  1, 0, 1, 1, 0, 8'hFF);
      push(4'h6, 1, 1, a[23:16], 1, 0, 1, 1, 0, 8'hFF);
      push(4'h7, 1, 1, {7'b0, a[24]}, 1, 0, 1, 1, 0, 8'hFF);
      if (wr) begin
         for (int b = 0; b < 4; b++) begin
            logic [7:0] by;
            by = wd[8*b +: 8];
            push(4'h5, 1,     1, by, 0, 0, 1, 1, 0, 8'hFF);
            push(4'h4, s + 1, 1, by, 0, 0, 1, 1, 0, 8'hFF);
            push(4'hC, p + 1, 1, by, 0, 0, 0, 1, 0, 8'hFF);
            push(4'hE, h + 1, 1, by, 0, 0, 1, 1, 0, 8'hFF);
         end
         push(4'h9, 1, 0, 8'h00, 0, 0, 1, 1, 1, 8'hFF);
      end else begin
         push(4'hF, 1, 0, 8'h00, 0, 0, 1, 0, 0, 8'hFF);
         for (int b = 0; b < 4; b++) begin
            logic [7:0] by;
            by = rd[8*b +: 8];
            push(4'h4, s + 1, 0, 8'h00, 0, 0, 1, 0, 0, ~by);
            push(4'hC, p + 1, 0, 8'h00, 0, 0, 1, 0, 0, ~by);
            push(4'hB, 1,     0, 8'h00, 0, 0, 1, 0, 0, by);
            push(4'hD, 1,     0, 8'h00, 0, 0, 1, 0, 0, ~by);
         end
         push(4'hE, h + 1, 0, 8'h00, 0, 0, 1, 0, 0, 8'h5A);
         r = idle_rec();
         r.code = 4'h9; r.first = 1'b1; r.cs_n = 1'b0; r.pready = 1'b1;
         r.rdchk = 1'b1; r.rd = rd;
         exp_q.push_back(r);
      end
      push(4'h8, 1, 0, 8'h00, 0, 1, 1, 1, 0, 8'hFF);
      push(4'h0, 1, 0, 8'h00, 0, 1, 1, 1, 0, 8'hFF);
   endtask

   task automatic step();
      rec_t        r;
      logic [15:0] ev;
      @(negedge clk);
      if (exp_q.size() != 0) r = exp_q.pop_front();
      else                   r = idle_rec();
      ev = r.first ? (16'd1 << r.code) : 16'd0;
      n_vec++;
      if ({bus_ad_oe, bus_ad_o, bus_ale, bus_cs_n, bus_we_n, bus_oe_n, pready, pslverr} !==
          {r.ad_oe, r.ad_o, r.ale, r.cs_n, r.we_n, r.oe_n, r.pready, 1'b0}) begin
         n_fail++;
         $display("FAIL %s state %h: actual oe=%b ad=%h ale=%b cs_n=%b we_n=%b oe_n=%b rdy=%b err=%b expected oe=%b ad=%h ale=%b cs_n=%b we_n=%b oe_n=%b rdy=%b err=0",
                  tag(r.code), r.code, bus_ad_oe, bus_ad_o, bus_ale, bus_cs_n, bus_we_n,
                  bus_oe_n, pready, pslverr, r.ad_oe, r.ad_o, r.ale, r.cs_n, r.we_n,
                  r.oe_n, r.pready);
      end
      n_vec++;
      if (evt_o !== ev) begin
         n_fail++;
         $display("FAIL R9 state %h: actual evt=%h expected %h", r.code, evt_o, ev);
      end
      n_vec++;
      if (bus_ad_oe && !bus_oe_n) begin
         n_fail++;
         $display("FAIL R10: actual driver on with read strobe low, expected never");
      end
      if (r.rdchk) begin
         n_vec++;
         if (prdata !== r.rd) begin
            n_fail++;
            $display("FAIL R6 packed word: actual %h expected %h", prdata, r.rd);
         end
      end
      bus_ad_i = r.drv;
      if (r.code == 4'h1 && r.first) penable = 1'b1;
      if (r.code == 4'h8) begin
         psel = 1'b0;
         penable = 1'b0;
      end
   endtask

   task automatic access(input bit wr, input logic [24:0] a, input logic [31:0] wd,
                         input logic [31:0] rd, input int s, input int p, input int h);
      cfg_setup = 4'(s); cfg_pulse = 4'(p); cfg_hold = 4'(h);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
      plan(wr, a, wd, rd, s, p, h);
      while (exp_q.size() != 0) step();
   endtask

   initial begin
      // R1: released bus while reset is held
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         n_vec++;
         if ({bus_cs_n, bus_ad_oe, pready, bus_we_n, bus_oe_n, evt_o} !== {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0}) begin
            n_fail++;
            $display("FAIL R1 in reset: actual cs_n=%b oe=%b rdy=%b evt=%h expected 1 0 0 0000",
                     bus_cs_n, bus_ad_oe, pready, evt_o);
         end
      end
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step();

      // R3 R4: write, minimum dwell, top address bit set
      access(1'b1, 25'h1_23_45_67, 32'hDEAD_BEEF, 32'h0, 0, 0, 0);
      // R5 R6: read with mixed dwell
      access(1'b0, 25'h0_AB_CD_EF, 32'h0, 32'h1234_A5C3, 2, 3, 1);
      step();
      // R4: maximum setup dwell on a write
      access(1'b1, 25'h0_00_00_01, 32'h00FF_8001, 32'h0, 15, 1, 4);
      // R8: back-to-back read started in the idle cycle after release
      access(1'b0, 25'h1_FF_FF_FF, 32'h0, 32'hFFFF_FFFF, 0, 0, 0);
      // R4 R6: long strobe on a read, single-bit lanes
      access(1'b0, 25'h1_00_80_00, 32'h0, 32'h8000_0001, 1, 15, 0);
      // R2: write with top bit clear and long hold
      access(1'b1, 25'h0_5A_C3_3C, 32'h0102_0408, 32'h0, 1, 2, 15);
      for (int i = 0; i < 4; i++) step();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule